// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the processor-facing register front end of a legacy keyboard and auxiliary-device controller. Software reaches it through two byte-wide locations: a data location and a command/status location. Command bytes are decoded into mode-register updates, output-port changes, address-line-20 gate control, system reset requests and one-byte responses. Reading the command/status location returns the status byte.

Some commands take an argument byte. Such a command is remembered as a pending write. The next byte written to the data location is then consumed as its operand, and the pending write is cleared. A data byte that arrives with nothing pending goes to the keyboard. Response bytes leave through a one-cycle strobe that carries a keyboard/aux tag. The output-buffer arbiter outside this block takes them from there, and it reports its buffer-full flags back for the status byte. Bytes for the keyboard or the aux device leave through their own one-cycle strobes. The serial line protocol and interrupt routing are handled elsewhere.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset the mode byte is 0x03, the output port is 0xCF, the A20 gate output is high, the error flag is low, and no strobe or reset pulse is active.
- R2: A status read (rd_i with addr_i=1) returns the status byte on rdata_o in the following cycle. The status bits are:
  - bit 0: obf_i
  - bit 1: 0
  - bit 2: self-test passed
  - bit 3: 1 when the last write was to the command location, 0 when it was to the data location
  - bit 4: 1
  - bit 5: aux_obf_i
  - bits 6 and 7: 0

  The status byte is 0x18 after reset with no buffer full.
- R3: The following commands emit one response byte with rsp_valid_o high for one cycle, one clock after the write, tagged keyboard (rsp_aux_o=0):
  - 0x20 returns the mode byte.
  - 0xA9 and 0xAB return 0x00.
  - 0xC0 returns 0x80.
  - 0xD0 returns the output port.
  - 0xAA returns 0x55 and also sets status bit 2.
- R4: Command 0xD2 makes the next data byte a keyboard-tagged response. Command 0xD3 makes it an aux-tagged response (rsp_aux_o=1). The command write itself emits nothing.
- R5: Command 0x60 makes the next data byte the new mode byte, including bit 6 (translation enable) on mode_o. The pending write is then cleared, so the data byte after that goes to the keyboard.
- R6: A data byte with no pending command pulses kbd_tx_valid_o and clears mode bit 4. After command 0xD4, the next data byte pulses aux_tx_valid_o and clears mode bit 5. In both cases the byte appears on tx_data_o.
- R7: The channel-disable commands act on the mode byte as follows:
  - 0xAD sets mode bit 4 and 0xAE clears it.
  - 0xA7 sets mode bit 5 and 0xA8 clears it.
- R8: Command 0xDD clears output-port bit 1 and drives A20 low. Command 0xDF sets output-port bit 1 and drives A20 high.
- R9: After command 0xD1, the next data byte becomes the output port, and A20 follows bit 1 of that byte. If bit 0 of that byte is 0, sys_rst_o pulses high for exactly one cycle.
- R10: A command whose upper nibble is 0xF is a pulse command. With bit 0 clear it produces a one-cycle sys_rst_o pulse. With bit 0 set it does nothing, and the output port is unchanged.
- R11: A command byte outside the set above changes no mode, port or response state. It sets err_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | 0 selects data, 1 selects command/status |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| wdata_i | input | 8 | Write data |
| obf_i | input | 1 | Output buffer full, from the arbiter |
| aux_obf_i | input | 1 | Buffered byte is from aux, from the arbiter |
| rdata_o | output | 8 | Read data: status byte, or 0 for a data-location read |
| mode_o | output | 8 | Mode byte |
| outport_o | output | 8 | Output port |
| a20_o | output | 1 | Address-line-20 gate |
| sys_rst_o | output | 1 | One-cycle system reset request |
| rsp_valid_o | output | 1 | Response byte strobe |
| rsp_aux_o | output | 1 | Response tag: 1 for aux, 0 for keyboard |
| rsp_data_o | output | 8 | Response byte |
| kbd_tx_valid_o | output | 1 | Byte-to-keyboard strobe |
| aux_tx_valid_o | output | 1 | Byte-to-aux-device strobe |
| tx_data_o | output | 8 | Byte forwarded to the keyboard or aux device |
| err_o | output | 1 | Sticky unknown-command flag |

## Verification
The assertions assume that wr_i and rd_i are never high together. They also assume that the pending-command state seen by the checker changes only on write strobes, so a reset pulse or a response strobe can always be traced back to a write in the previous cycle. The stimulus drives single-cycle strobes from tasks at the falling clock edge and never overlaps a read with a write. It holds obf_i and aux_obf_i steady around each status read, so the sampled status byte is unambiguous.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_KBD_OFF = 4;
  localparam int MODE_AUX_OFF = 5;

  typedef enum logic [2:0] {
    PEND_NONE = 3'd0,
    PEND_MODE = 3'd1,
    PEND_OUTP = 3'd2,
    PEND_KRSP = 3'd3,
    PEND_ARSP = 3'd4,
    PEND_ATX  = 3'd5
  } pend_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_MODE  = 2'd1,
    RSP_OUTP  = 2'd2,
    RSP_CONST = 2'd3
  } rsp_src_e;

  typedef struct packed {
    logic              known;
    pend_e             latch;
    rsp_src_e          rsp;
    logic [BYTE_W-1:0] rsp_const;
    logic              selftest;
    logic [BYTE_W-1:0] mode_set;
    logic [BYTE_W-1:0] mode_clr;
    logic              a20_up;
    logic              a20_dn;
    logic              rst_req;
  } cmd_dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_dec_t          dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.known = 1'b1;
    if (cmd_i[7:4] == 4'hF) begin
      // pulse family: even code requests reset, odd code is a no-op
      dec_o.rst_req = ~cmd_i[0];
    end else begin
      unique case (cmd_i)
        8'h20: dec_o.rsp = RSP_MODE;
        8'h60: dec_o.latch = PEND_MODE;
        8'hA7: dec_o.mode_set[MODE_AUX_OFF] = 1'b1;
        8'hA8: dec_o.mode_clr[MODE_AUX_OFF] = 1'b1;
        8'hA9, 8'hAB: begin
          dec_o.rsp       = RSP_CONST;
          dec_o.rsp_const = 8'h00;
        end
        8'hAA: begin
          dec_o.rsp       = RSP_CONST;
          dec_o.rsp_const = 8'h55;
          dec_o.selftest  = 1'b1;
        end
        8'hAD: dec_o.mode_set[MODE_KBD_OFF] = 1'b1;
        8'hAE: dec_o.mode_clr[MODE_KBD_OFF] = 1'b1;
        8'hC0: begin
          dec_o.rsp       = RSP_CONST;
          dec_o.rsp_const = 8'h80;
        end
        8'hD0: dec_o.rsp = RSP_OUTP;
        8'hD1: dec_o.latch = PEND_OUTP;
        8'hD2: dec_o.latch = PEND_KRSP;
        8'hD3: dec_o.latch = PEND_ARSP;
        8'hD4: dec_o.latch = PEND_ATX;
        8'hDD: dec_o.a20_dn = 1'b1;
        8'hDF: dec_o.a20_up = 1'b1;
        default: dec_o.known = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_VAL = 8'hCF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              a20_up_i,
  input  logic              a20_dn_i,
  input  logic              pulse_i,
  output logic [BYTE_W-1:0] outport_o,
  output logic              a20_o,
  output logic              sys_rst_o
);
  localparam int A20_BIT = 1;
  logic [BYTE_W-1:0] port_q;
  logic              rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= RST_VAL;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= pulse_i | (we_i & ~wdata_i[0]);
      if (we_i)          port_q <= wdata_i;
      else if (a20_up_i) port_q[A20_BIT] <= 1'b1;
      else if (a20_dn_i) port_q[A20_BIT] <= 1'b0;
    end
  end

  assign outport_o = port_q;
  assign a20_o     = port_q[A20_BIT];
  assign sys_rst_o = rst_q;
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
  parameter logic [BYTE_W-1:0] PORT_RST = 8'hCF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              obf_i,
  input  logic              aux_obf_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] outport_o,
  output logic              a20_o,
  output logic              sys_rst_o,
  output logic              rsp_valid_o,
  output logic              rsp_aux_o,
  output logic [BYTE_W-1:0] rsp_data_o,
  output logic              kbd_tx_valid_o,
  output logic              aux_tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              err_o
);
  cmd_dec_t          dec;
  pend_e             pend_q;
  logic [BYTE_W-1:0] mode_q, rdata_q, rsp_data_q, tx_data_q;
  logic              selftest_q, cmd_last_q, err_q;
  logic              rsp_valid_q, rsp_aux_q, kbd_tx_q, aux_tx_q;
  logic [BYTE_W-1:0] status;
  logic              cmd_wr, dat_wr, cmd_ok, port_we;

  assign cmd_wr  = wr_i & addr_i;
  assign dat_wr  = wr_i & ~addr_i;
  assign cmd_ok  = cmd_wr & dec.known;
  assign port_we = dat_wr & (pend_q == PEND_OUTP);

  kbc_cmd_decode u_dec (
    .cmd_i (wdata_i),
    .dec_o (dec)
  );

  kbc_outport #(.RST_VAL(PORT_RST)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (port_we),
    .wdata_i   (wdata_i),
    .a20_up_i  (cmd_ok & dec.a20_up),
    .a20_dn_i  (cmd_ok & dec.a20_dn),
    .pulse_i   (cmd_ok & dec.rst_req),
    .outport_o (outport_o),
    .a20_o     (a20_o),
    .sys_rst_o (sys_rst_o)
  );

  assign status = {2'b00, aux_obf_i, 1'b1, cmd_last_q, selftest_q, 1'b0, obf_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_RST;
      pend_q      <= PEND_NONE;
      selftest_q  <= 1'b0;
      cmd_last_q  <= 1'b1;
      err_q       <= 1'b0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_aux_q   <= 1'b0;
      rsp_data_q  <= '0;
      kbd_tx_q    <= 1'b0;
      aux_tx_q    <= 1'b0;
      tx_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      kbd_tx_q    <= 1'b0;
      aux_tx_q    <= 1'b0;
      if (rd_i) rdata_q <= addr_i ? status : '0;

      if (cmd_wr) begin
        cmd_last_q <= 1'b1;
        if (!dec.known) begin
          err_q <= 1'b1;
        end else begin
          if (dec.latch != PEND_NONE) pend_q <= dec.latch;
          if (dec.selftest) selftest_q <= 1'b1;
          mode_q <= (mode_q | dec.mode_set) & ~dec.mode_clr;
          if (dec.rsp != RSP_NONE) begin
            rsp_valid_q <= 1'b1;
            rsp_aux_q   <= 1'b0;
            unique case (dec.rsp)
              RSP_MODE: rsp_data_q <= mode_q;
              RSP_OUTP: rsp_data_q <= outport_o;
              default:  rsp_data_q <= dec.rsp_const;
            endcase
          end
        end
      end

      if (dat_wr) begin
        cmd_last_q <= 1'b0;
        pend_q     <= PEND_NONE;
        unique case (pend_q)
          PEND_NONE: begin
            kbd_tx_q             <= 1'b1;
            tx_data_q            <= wdata_i;
            mode_q[MODE_KBD_OFF] <= 1'b0;
          end
          PEND_MODE: mode_q <= wdata_i;
          PEND_KRSP, PEND_ARSP: begin
            rsp_valid_q <= 1'b1;
            rsp_aux_q   <= (pend_q == PEND_ARSP);
            rsp_data_q  <= wdata_i;
          end
          PEND_ATX: begin
            aux_tx_q             <= 1'b1;
            tx_data_q            <= wdata_i;
            mode_q[MODE_AUX_OFF] <= 1'b0;
          end
          default: ; // output port handled in u_port
        endcase
      end
    end
  end

  assign rdata_o        = rdata_q;
  assign mode_o         = mode_q;
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_aux_o      = rsp_aux_q;
  assign rsp_data_o     = rsp_data_q;
  assign kbd_tx_valid_o = kbd_tx_q;
  assign aux_tx_valid_o = aux_tx_q;
  assign tx_data_o      = tx_data_q;
  assign err_o          = err_q;
endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [2:0] pend_i,
  input logic [7:0] mode_o,
  input logic       a20_o,
  input logic       sys_rst_o,
  input logic       rsp_valid_o,
  input logic       kbd_tx_valid_o,
  input logic       aux_tx_valid_o,
  input logic       err_o
);
  a_r9_rst_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $past(wr_i && !wdata_i[0]));

  a_r10_odd_pulse_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i[7:4] == 4'hF && wdata_i[0]) |=> !sys_rst_o);

  a_r8_a20_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i == 8'hDF) |=> a20_o);

  a_r8_a20_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i == 8'hDD) |=> !a20_o);

  a_r6_kbd_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && pend_i == 3'd0) |=> (kbd_tx_valid_o && !mode_o[4]));

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_valid_o, kbd_tx_valid_o, aux_tx_valid_o}));

  a_r3_rsp_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(wr_i));
endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wr_i           (wr_i),
  .wdata_i        (wdata_i),
  .pend_i         (pend_q),
  .mode_o         (mode_o),
  .a20_o          (a20_o),
  .sys_rst_o      (sys_rst_o),
  .rsp_valid_o    (rsp_valid_o),
  .kbd_tx_valid_o (kbd_tx_valid_o),
  .aux_tx_valid_o (aux_tx_valid_o),
  .err_o          (err_o)
);

// File: tb/kbc_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module kbc_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, obf = 1'b0, aux_obf = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mode, outport, rsp_data, tx_data;
  logic       a20, sys_rst, rsp_valid, rsp_aux, kbd_tx, aux_tx, err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kbc_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .obf_i(obf), .aux_obf_i(aux_obf), .rdata_o(rdata),
    .mode_o(mode), .outport_o(outport), .a20_o(a20), .sys_rst_o(sys_rst),
    .rsp_valid_o(rsp_valid), .rsp_aux_o(rsp_aux), .rsp_data_o(rsp_data),
    .kbd_tx_valid_o(kbd_tx), .aux_tx_valid_o(aux_tx), .tx_data_o(tx_data),
    .err_o(err)
  );

  // {command, expected response}
  localparam logic [15:0] RSP_VEC [0:5] = '{
    16'h2003, 16'hA900, 16'hAB00, 16'hC080, 16'hD0CF, 16'hAA55
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    addr = 1'b1; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 8'h03);
    chk("R1 outport", outport, 8'hCF);
    chk("R1 a20", {7'b0, a20}, 8'h01);
    chk("R1 strobes", {3'b0, err, sys_rst, rsp_valid, kbd_tx, aux_tx}, 8'h00);
    rd_status(st);
    chk("R2 status after reset", st, 8'h18);

    // R3 response table
    foreach (RSP_VEC[i]) begin
      wr_byte(1'b1, RSP_VEC[i][15:8]);
      chk("R3 rsp valid", {7'b0, rsp_valid}, 8'h01);
      chk("R3 rsp tag", {7'b0, rsp_aux}, 8'h00);
      chk("R3 rsp data", rsp_data, RSP_VEC[i][7:0]);
    end
    @(negedge clk);
    chk("R3 strobe one cycle", {7'b0, rsp_valid}, 8'h00);

    // R2 status bits
    rd_status(st);
    chk("R2 selftest+cmd", st, 8'h1C);
    obf = 1'b1; aux_obf = 1'b1;
    rd_status(st);
    chk("R2 buffer flags", st, 8'h3D);
    obf = 1'b0; aux_obf = 1'b0;

    // R6 plain data goes to keyboard
    wr_byte(1'b0, 8'h11);
    chk("R6 kbd tx", {7'b0, kbd_tx}, 8'h01);
    chk("R6 tx data", tx_data, 8'h11);
    rd_status(st);
    chk("R2 data write clears bit3", st, 8'h14);

    // R4 two-byte responses
    wr_byte(1'b1, 8'hD2);
    chk("R4 latch emits nothing", {7'b0, rsp_valid}, 8'h00);
    wr_byte(1'b0, 8'h5A);
    chk("R4 kbd rsp", {rsp_valid, rsp_aux, 6'b0}, 8'h80);
    chk("R4 kbd rsp data", rsp_data, 8'h5A);
    wr_byte(1'b1, 8'hD3);
    wr_byte(1'b0, 8'hA5);
    chk("R4 aux rsp", {rsp_valid, rsp_aux, 6'b0}, 8'hC0);
    chk("R4 aux rsp data", rsp_data, 8'hA5);

    // R5 mode write
    wr_byte(1'b1, 8'h60);
    wr_byte(1'b0, 8'h47);
    chk("R5 mode write", mode, 8'h47);
    wr_byte(1'b1, 8'h20);
    chk("R5 mode readback", rsp_data, 8'h47);

    // R7 enable/disable
    wr_byte(1'b1, 8'hAD); chk("R7 AD", mode, 8'h57);
    wr_byte(1'b1, 8'hAE); chk("R7 AE", mode, 8'h47);
    wr_byte(1'b1, 8'hA7); chk("R7 A7", mode, 8'h67);
    wr_byte(1'b1, 8'hA8); chk("R7 A8", mode, 8'h47);

    // R5/R6 pending cleared, forwarding clears disable bits
    wr_byte(1'b1, 8'h60);
    wr_byte(1'b0, 8'h33);
    chk("R5 mode 33", mode, 8'h33);
    wr_byte(1'b0, 8'h99);
    chk("R5 pending cleared", {7'b0, kbd_tx}, 8'h01);
    chk("R6 kbd clears bit4", mode, 8'h23);
    wr_byte(1'b1, 8'hD4);
    wr_byte(1'b0, 8'h22);
    chk("R6 aux tx", {kbd_tx, aux_tx, 6'b0}, 8'h40);
    chk("R6 aux data", tx_data, 8'h22);
    chk("R6 aux clears bit5", mode, 8'h03);

    // R8 A20 commands
    wr_byte(1'b1, 8'hDD);
    chk("R8 DD a20", {7'b0, a20}, 8'h00);
    chk("R8 DD port", outport, 8'hCD);
    wr_byte(1'b1, 8'hDF);
    chk("R8 DF a20", {7'b0, a20}, 8'h01);
    chk("R8 DF port", outport, 8'hCF);

    // R9 output port write
    wr_byte(1'b1, 8'hD1);
    wr_byte(1'b0, 8'h01);
    chk("R9 port 01", outport, 8'h01);
    chk("R9 a20 low, no reset", {6'b0, a20, sys_rst}, 8'h00);
    wr_byte(1'b1, 8'hD1);
    wr_byte(1'b0, 8'hCE);
    chk("R9 port CE", outport, 8'hCE);
    chk("R9 reset pulse", {6'b0, a20, sys_rst}, 8'h03);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'b0, sys_rst}, 8'h00);
    wr_byte(1'b1, 8'hD1);
    wr_byte(1'b0, 8'hCF);

    // R10 pulse family
    wr_byte(1'b1, 8'hF0); chk("R10 F0 reset", {7'b0, sys_rst}, 8'h01);
    wr_byte(1'b1, 8'hFE); chk("R10 FE reset", {7'b0, sys_rst}, 8'h01);
    wr_byte(1'b1, 8'hF1); chk("R10 F1 quiet", {7'b0, sys_rst}, 8'h00);
    chk("R10 F1 port unchanged", outport, 8'hCF);
    wr_byte(1'b1, 8'hFF); chk("R10 FF quiet", {7'b0, sys_rst}, 8'h00);

    // R11 unknown command
    chk("R11 err clear", {7'b0, err}, 8'h00);
    wr_byte(1'b1, 8'h12);
    chk("R11 err set", {7'b0, err}, 8'h01);
    chk("R11 mode unchanged", mode, 8'h03);
    chk("R11 no rsp", {7'b0, rsp_valid}, 8'h00);
    wr_byte(1'b1, 8'hA7);
    chk("R11 err sticky", {7'b0, err}, 8'h01);
    chk("R11 later cmd works", mode, 8'h23);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", mode, 8'h03);
    chk("R1 err after reset", {7'b0, err}, 8'h00);
    chk("R1 outport after reset", outport, 8'hCF);
    rd_status(st);
    chk("R1 status after reset", st, 8'h18);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule